// File: doc/BRIEF.md
# Serial ADC Host Reader

This block is the host side of a three-wire link to a 16-bit successive-approximation converter. From the fast system clock it drives an active-low chip select and a divided serial clock, and it reads the converter's data line. Each frame starts with a five-period sampling window and one null bit that must read low. The result bits follow, most significant first, and the block packs them into a 16-bit two's complement word.

A frame begins with a one-cycle start request. The requested bit count is sampled with it. The host may ask for anywhere from 3 to 16 result bits. A short read ends the frame early by raising chip select once the last requested bit has been captured. This cuts the converter's active time. The result is offered on a valid/ready port together with the number of bits actually read and a flag that reports a bad null bit. Chip select stays high for a guaranteed gap before the result is offered. The block accepts no new start until that result has been taken.

Top module: `sar_serial_reader`

## Requirements
- R1: While reset is applied and while idle, `cs_n` is high, `sclk` is low, `busy` is low and `res_valid` is low.
- R2: A `start_req` seen while `busy` is low is accepted: `cs_n` goes low and `busy` goes high one cycle later. `sclk` then stays low for one full phase before its first rising edge.
- R3: Every high phase and every low phase of `sclk` inside a frame lasts exactly P system cycles. P is the larger of `HALF_DIV` and ceil(`MIN_PHASE_NS` / `SYS_PERIOD_NS`). The defaults give P = 10.
- R4: The 5-bit `read_bits` is sampled only at the accepted start and is clamped to the range 3..16. The clamped value n is reported on `res_bits`. Later changes to `read_bits` have no effect on the frame.
- R5: A frame has exactly 6 + n rising `sclk` edges. Edges 1 to 5 are ignored, edge 6 samples the null bit, and edges 7 to 6+n capture result bits 15 downward.
- R6: `res_data` holds the captured bits left-aligned with bit 15 first. The 16 - n unread low bits are zero.
- R7: `res_frame_err` is 1 with the result exactly when `sdata` was high at the null-bit edge.
- R8: `cs_n` rises together with the falling `sclk` edge that ends the high phase of the last capture. `res_valid` rises `IDLE_CYC` cycles after `cs_n` rises.
- R9: `res_valid`, `res_data`, `res_bits` and `res_frame_err` hold steady until a cycle with `res_ready` high. After that cycle `res_valid` drops.
- R10: `busy` stays high from the accepted start until the result handshake. A `start_req` while `busy` is high is ignored and does not start a later frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | One-cycle request to read one sample |
| read_bits | input | 5 | Requested result bit count, clamped to 3..16 |
| busy | output | 1 | A frame, gap or pending result is in progress |
| cs_n | output | 1 | Converter chip select, active low; high means power-down |
| sclk | output | 1 | Divided serial data clock |
| sdata | input | 1 | Serial data from the converter |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | 16 | Left-aligned two's complement result |
| res_bits | output | 5 | Number of result bits actually read |
| res_frame_err | output | 1 | Null bit was read high |

## Verification
The bound checker covers the rules that hold on every cycle. These are the idle line levels, the start-to-chip-select response, the exact length of each clock phase (counted in the checker), the rule that the clock is low whenever chip select is high, the result holding steady under back-pressure, the legal range of the bit count and the zeroed low bits of the result. The bench scenarios cover the rest. A bench model of the converter shifts a known word out on falling edges, so only the scenarios can show that the right bits land in the right positions after the sampling window and null bit. The scenarios also show that clamped counts of 0, 2, 20 and 31 give the edge counts and masks they should, that a high null bit raises the error flag, and that a start issued mid-frame never produces an extra frame.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

  localparam int RES_W      = 16;
  localparam int CNT_W      = 5;
  localparam int LEAD_EDGES = 6;   // five sampling periods plus the null bit
  localparam int MIN_READ   = 3;

  typedef enum logic [1:0] {
    RD_IDLE,
    RD_FRAME,
    RD_GAP,
    RD_HOLD
  } rd_state_e;

  // System cycles per serial clock phase: the requested divider, raised to
  // the smallest count that still meets the minimum phase time.
  function automatic int phase_cycles(int div, int sys_ns, int min_ns);
    int need;
    need = (min_ns + sys_ns - 1) / sys_ns;
    return (div > need) ? div : need;
  endfunction

  // Bring a requested bit count into the legal 3..16 range.
  function automatic logic [CNT_W-1:0] clamp_count(logic [CNT_W-1:0] req);
    logic [CNT_W-1:0] lo_c;
    logic [CNT_W-1:0] hi_c;
    lo_c = CNT_W'(MIN_READ);
    hi_c = CNT_W'(RES_W);
    if (req < lo_c) return lo_c;
    if (req > hi_c) return hi_c;
    return req;
  endfunction

endpackage

// File: rtl/sar_rd_clkgen.sv
module sar_rd_clkgen #(
  parameter int PHASE_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int PW = $clog2(PHASE_CYC + 1);

  logic [PW-1:0] cnt;
  logic          sclk_q;
  logic          wrap;

  assign wrap = (cnt == PW'(PHASE_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sclk_q <= 1'b0;
    end else if (!run) begin
      cnt    <= '0;
      sclk_q <= 1'b0;
    end else if (wrap) begin
      cnt    <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt    <= cnt + 1'b1;
    end
  end

  // Ticks mark the cycle whose edge toggles the clock output.
  assign rise_tick = run & wrap & ~sclk_q;
  assign fall_tick = run & wrap &  sclk_q;
  assign sclk      = sclk_q;

endmodule

// File: rtl/sar_rd_shifter.sv
module sar_rd_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load_en,
  input  logic         din,
  output logic [W-1:0] word
);
  localparam int PW = $clog2(W);

  logic [PW-1:0] ptr;

  // Bits land from the top down, so a short read is left-aligned and its
  // untouched low bits keep the zeros written by clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      ptr  <= PW'(W - 1);
    end else if (clear) begin
      word <= '0;
      ptr  <= PW'(W - 1);
    end else if (load_en) begin
      word[ptr] <= din;
      ptr       <= ptr - 1'b1;
    end
  end

endmodule

// File: rtl/sar_serial_reader.sv
module sar_serial_reader
  import sar_rd_pkg::*;
#(
  parameter int HALF_DIV      = 2,
  parameter int SYS_PERIOD_NS = 20,
  parameter int MIN_PHASE_NS  = 200,
  parameter int IDLE_CYC      = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_req,
  input  logic [4:0]  read_bits,
  output logic        busy,
  output logic        cs_n,
  output logic        sclk,
  input  logic        sdata,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [15:0] res_data,
  output logic [4:0]  res_bits,
  output logic        res_frame_err
);
  localparam int EFF_HALF = phase_cycles(HALF_DIV, SYS_PERIOD_NS, MIN_PHASE_NS);
  localparam int GW       = $clog2(IDLE_CYC + 1);

  rd_state_e        state;
  logic             cs_q;
  logic [CNT_W-1:0] n_q;
  logic [5:0]       edge_q;
  logic [GW-1:0]    gap_q;
  logic             err_q;

  // Named internal events
  logic       frame_run;
  logic       rise_tick;
  logic       fall_tick;
  logic       accept;
  logic       null_tick;
  logic       capture_tick;
  logic       last_fall;
  logic       gap_done;
  logic [5:0] last_edge;

  assign frame_run    = (state == RD_FRAME);
  assign accept       = start_req && (state == RD_IDLE);
  assign last_edge    = 6'(LEAD_EDGES) + {1'b0, n_q};
  assign null_tick    = rise_tick && (edge_q == 6'(LEAD_EDGES - 1));
  assign capture_tick = rise_tick && (edge_q >= 6'(LEAD_EDGES)) && (edge_q < last_edge);
  assign last_fall    = fall_tick && (edge_q == last_edge);
  assign gap_done     = (state == RD_GAP) && (gap_q == GW'(IDLE_CYC - 1));

  sar_rd_clkgen #(.PHASE_CYC(EFF_HALF)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (frame_run),
    .sclk      (sclk),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  sar_rd_shifter #(.W(RES_W)) u_shifter (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .load_en (capture_tick),
    .din     (sdata),
    .word    (res_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RD_IDLE;
      cs_q   <= 1'b1;
      n_q    <= CNT_W'(MIN_READ);
      edge_q <= '0;
      gap_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      case (state)
        RD_IDLE: begin
          if (start_req) begin
            state  <= RD_FRAME;
            cs_q   <= 1'b0;
            n_q    <= clamp_count(read_bits);
            edge_q <= '0;
            err_q  <= 1'b0;
          end
        end
        RD_FRAME: begin
          if (rise_tick) edge_q <= edge_q + 6'd1;
          if (null_tick) err_q  <= sdata;
          if (last_fall) begin
            state <= RD_GAP;
            cs_q  <= 1'b1;
            gap_q <= '0;
          end
        end
        RD_GAP: begin
          if (gap_done) state <= RD_HOLD;
          else          gap_q <= gap_q + 1'b1;
        end
        RD_HOLD: begin
          if (res_ready) state <= RD_IDLE;
        end
        default: state <= RD_IDLE;
      endcase
    end
  end

  assign cs_n          = cs_q;
  assign busy          = (state != RD_IDLE);
  assign res_valid     = (state == RD_HOLD);
  assign res_bits      = n_q;
  assign res_frame_err = err_q;

endmodule

// File: rtl/sar_rd_checker.sv
module sar_rd_checker #(
  parameter int PHASE_CYC = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start_req,
  input logic        busy,
  input logic        cs_n,
  input logic        sclk,
  input logic        res_valid,
  input logic        res_ready,
  input logic [15:0] res_data,
  input logic [4:0]  res_bits
);
  logic        last_sclk;
  logic [15:0] hi_len;
  logic [15:0] lo_len;

  // Phase lengths measured as consecutive sampled cycles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_sclk <= 1'b0;
      hi_len    <= '0;
      lo_len    <= '0;
    end else begin
      last_sclk <= sclk;
      if (sclk) hi_len <= (hi_len == 16'hFFFF) ? hi_len : hi_len + 16'd1;
      else      hi_len <= '0;
      if (!sclk && !cs_n) lo_len <= (lo_len == 16'hFFFF) ? lo_len : lo_len + 16'd1;
      else                lo_len <= '0;
    end
  end

  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sclk));

  p_start_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_req) |=> (!cs_n && busy));

  p_clk_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  p_high_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk && last_sclk) |-> (hi_len == 16'(PHASE_CYC)));

  p_low_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && !last_sclk) |-> (lo_len == 16'(PHASE_CYC)));

  p_count_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_bits >= 5'd3 && res_bits <= 5'd16));

  p_low_bits_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_data << res_bits) == 16'd0));

  p_result_after_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (cs_n && !sclk));

  p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_bits)));

  p_busy_with_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> busy);

endmodule

bind sar_serial_reader sar_rd_checker #(.PHASE_CYC(EFF_HALF)) u_rd_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_req (start_req),
  .busy      (busy),
  .cs_n      (cs_n),
  .sclk      (sclk),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data),
  .res_bits  (res_bits)
);

// File: tb/test_sar_serial_reader.sv
module test_sar_serial_reader;
  localparam int PHASE = 10;  // divider 2 raised to ceil(200/20)
  localparam int IDLE  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_req = 1'b0;
  logic [4:0]  read_bits = 5'd0;
  logic        sdata = 1'b1;
  logic        res_ready = 1'b0;
  wire         busy, cs_n, sclk, res_valid, res_frame_err;
  wire  [15:0] res_data;
  wire  [4:0]  res_bits;

  sar_serial_reader #(
    .HALF_DIV(2), .SYS_PERIOD_NS(20), .MIN_PHASE_NS(200), .IDLE_CYC(IDLE)
  ) i_sar_serial_reader (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .read_bits(read_bits),
    .busy(busy), .cs_n(cs_n), .sclk(sclk), .sdata(sdata),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_bits(res_bits), .res_frame_err(res_frame_err)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  typedef struct {
    logic [15:0] data;
    logic [4:0]  bits;
    logic        err;
  } exp_t;
  exp_t sb[$];

  // Converter model: shifts out on falling clock edges.
  logic [15:0] conv_word = 16'h0;
  logic        conv_null = 1'b0;
  int          fcnt = 0;

  always @(negedge cs_n) begin
    fcnt  = 0;
    sdata = 1'b1;
  end

  always @(negedge sclk) begin
    if (!cs_n) begin
      fcnt++;
      if (fcnt == 5)                    sdata = conv_null;
      else if (fcnt >= 6 && fcnt <= 21) sdata = conv_word[21 - fcnt];
      else                              sdata = 1'b1;
    end
  end

  // Line timing monitor
  int   rises = 0, hi_run = 0, lo_run = 0, gap_run = 0, frames = 0, to_valid = 0;
  int   exp_rises = 0;
  bit   wait_valid = 1'b0;
  logic p_sclk = 1'b0, p_cs = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n && p_cs) begin
        if (frames > 0) chk(gap_run >= IDLE + 1, "R8 chip-select high gap", gap_run, IDLE + 1);
        frames++;
        rises = 0;
      end
      if (cs_n && !p_cs) begin
        chk(rises == exp_rises, "R5 rising edges per frame", rises, exp_rises);
        chk(!sclk, "R8 clock low as chip select rises", sclk, 0);
        chk(busy, "R10 busy through frame end", busy, 1);
        gap_run    = 0;
        to_valid   = 0;
        wait_valid = 1'b1;
      end
      if (wait_valid) begin
        if (res_valid) begin
          chk(to_valid == IDLE, "R8 valid delay after chip select", to_valid, IDLE);
          wait_valid = 1'b0;
        end else to_valid++;
      end
      if (sclk && !p_sclk) begin
        rises++;
        chk(lo_run == PHASE, (rises == 1) ? "R2 setup low phase" : "R3 low phase", lo_run, PHASE);
      end
      if (!sclk && p_sclk) chk(hi_run == PHASE, "R3 high phase", hi_run, PHASE);
      hi_run = sclk ? (p_sclk ? hi_run + 1 : 1) : 0;
      lo_run = (!sclk && !cs_n) ? ((!p_sclk && !p_cs) ? lo_run + 1 : 1) : 0;
      if (cs_n) gap_run++;
      p_sclk = sclk;
      p_cs   = cs_n;
    end
  end

  // Result monitor with back-pressure
  int   ready_delay = 0, hold_wait = 0, received = 0;
  bit   got = 1'b0;
  exp_t cur;

  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid && !got) begin
        got = 1'b1;
        hold_wait = 0;
        if (sb.size() == 0) chk(1'b0, "R10 unexpected result", 1, 0);
        else begin
          cur = sb.pop_front();
          chk(res_data == cur.data, "R6 left-aligned data", res_data, cur.data);
          chk(res_bits == cur.bits, "R4 clamped bit count", res_bits, cur.bits);
          chk(res_frame_err == cur.err, "R7 null-bit error flag", res_frame_err, cur.err);
        end
      end else if (res_valid && got && !res_ready) begin
        chk(res_data == cur.data && res_bits == cur.bits, "R9 result held", res_data, cur.data);
      end
      if (res_valid) begin
        if (hold_wait >= ready_delay) res_ready = 1'b1;
        else begin
          res_ready = 1'b0;
          hold_wait++;
        end
      end else begin
        res_ready = 1'b0;
        if (got) begin
          got = 1'b0;
          received++;
        end
      end
    end
  end

  task automatic do_read(input logic [15:0] w, input logic [4:0] req, input logic nb,
                         input int rdly, input bit poke);
    exp_t e;
    int   n;
    int   target;
    int   fr0;
    n = (req < 3) ? 3 : ((req > 16) ? 16 : int'(req));
    e.data = w & ~(16'hFFFF >> n);
    e.bits = 5'(n);
    e.err  = nb;
    sb.push_back(e);
    conv_word   = w;
    conv_null   = nb;
    exp_rises   = 6 + n;
    ready_delay = rdly;
    target      = received + 1;
    fr0         = frames;
    while (busy) @(negedge clk);
    start_req = 1'b1;
    read_bits = req;
    @(negedge clk);
    start_req = 1'b0;
    read_bits = 5'd7;  // R4: later changes must not matter
    chk(busy && !cs_n, "R2 start accepted", {busy, cs_n}, 2'b10);
    if (poke) begin
      repeat (60) @(negedge clk);
      start_req = 1'b1;
      read_bits = 5'd4;
      @(negedge clk);
      start_req = 1'b0;
    end
    while (received < target) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(frames == fr0 + 1, "R10 start while busy ignored", frames, fr0 + 1);
    chk(cs_n && !busy, "R1 idle after handshake", {cs_n, busy}, 2'b10);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(cs_n == 1'b1, "R1 reset chip select", cs_n, 1);
    chk(sclk == 1'b0, "R1 reset clock", sclk, 0);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    chk(res_valid == 1'b0, "R1 reset valid", res_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_read(16'hA5C3, 5'd16, 1'b0, 0, 1'b1);
    do_read(16'h7FFF, 5'd16, 1'b0, 3, 1'b0);
    do_read(16'h8000, 5'd16, 1'b0, 0, 1'b0);
    do_read(16'hFFFF, 5'd3,  1'b0, 0, 1'b0);
    do_read(16'hC234, 5'd0,  1'b0, 2, 1'b0);
    do_read(16'hBEEF, 5'd2,  1'b0, 0, 1'b0);
    do_read(16'h5A5A, 5'd8,  1'b1, 1, 1'b1);
    do_read(16'hDEAD, 5'd31, 1'b0, 0, 1'b0);
    do_read(16'h0F0F, 5'd20, 1'b1, 0, 1'b0);
    do_read(16'h3C96, 5'd13, 1'b0, 5, 1'b0);
    chk(sb.size() == 0, "R5 all frames returned", sb.size(), 0);
    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", received, 10);
      summary();
      $finish;
    end
  end

endmodule